// File: doc/BRIEF.md
# Register-Mapped UART Control Core

This block is the software-facing half of a byte-oriented serial port. A processor reaches it through a small register window on a 6-bit address bus. In that window it sets two mode bytes, issues commands, reads status, moves data bytes and programs an interrupt mask. On the line side the block does not serialize bits. It hands whole bytes to an external serializer and takes whole bytes from an external deserializer, each through a valid/ready handshake. A break-detected strobe also arrives from the line side.

Received bytes wait in a four-entry queue. Transmit bytes wait in a single holding register. One command byte carries three independent fields, so one write can reset a part of the port and switch the transmitter and receiver on or off. One level interrupt output is the OR of the unmasked interrupt status bits. Read data is combinational from the current address. A read strobe at the receive-data offset removes the oldest queued byte at the next clock edge.

Top module: `uart_regcore`

## Requirements
- R1: After reset both mode bytes, the interrupt mask and the interrupt status are zero. The status byte (offset 0x04) reads 0x08, which is the transmitter-empty bit alone. `irq`, `tx_valid` and `rx_ready` are low.
- R2: The two mode bytes share offset 0x00 through a pointer that starts at the first byte. A write stores into the byte the pointer selects and then moves the pointer to the second byte. A read returns the selected byte. A command whose bits [5:4] equal 1 moves the pointer back to the first byte.
- R3: In a command write at offset 0x08, bits [3:2] switch the transmitter (1 on, 2 off) and bits [1:0] switch the receiver (1 on, 2 off). The value 3 in either field changes nothing. Status bit 2 (transmitter ready) equals the transmitter enable.
- R4: A write at offset 0x0C loads the holding register and clears status bit 3 (transmitter empty). `tx_valid` is high while the transmitter is on and a byte is pending. `tx_data` stays stable until `tx_ready` is sampled high. Status bit 3 is then set again.
- R5: A command whose bits [5:4] equal 3 switches the transmitter off, sets transmitter empty and discards any pending byte.
- R6: The receive queue holds 4 bytes. `rx_ready` is high only when the receiver is on, the queue is not full and no break strobe is present. Status bit 0 means the queue is not empty, and status bit 1 means the queue is full.
- R7: A read strobe at offset 0x0C returns the oldest byte and removes it. When the queue is empty the read returns 0 and the queue does not change.
- R8: A break strobe sets interrupt status bit 2 and pushes a zero byte. It does so even when the receiver is off. When the queue is full, the zero byte replaces the newest entry.
- R9: A command whose bits [5:4] equal 2 switches the receiver off and empties the queue. A receiver-on field in the same command still switches the receiver on afterwards.
- R10: Interrupt status (read at offset 0x14) has bit 0 equal to transmitter ready and bit 2 equal to the break flag. Bit 1 follows queue-full when bit 6 of the first mode byte is set, and queue-not-empty when it is clear.
- R11: A write at offset 0x14 loads the interrupt mask. `irq` is high exactly when interrupt status AND mask is nonzero.
- R12: A command whose bits [6:4] equal 5 clears the break flag. Because the low two bits of that code are 01, the same command also resets the mode pointer.
- R13: Offsets 0x18 and 0x1C hold two divider bytes that read back as written. Writes at 0x04 and 0x10 have no effect. Reads at 0x08, 0x10 and any unused offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the queue at 0x0C) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Transmit byte offered to the serializer |
| tx_ready | input | 1 | Serializer accepts the byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Deserializer offers a byte |
| rx_ready | output | 1 | Core accepts the byte |
| rx_data | input | 8 | Received byte |
| brk_evt | input | 1 | Break detected strobe |

## Verification
The hardest case to reach is a break strobe that lands while the queue is full. The handshake never lets a data byte into a full queue, so the overwrite of the newest entry can only be reached with a break. The stimulus first streams more bytes than the queue holds, keeping `rx_valid` high past the point where `rx_ready` drops. It then pulses the break strobe and drains the queue by reads, which shows that the last entry became zero while the older three survived. The same full state, with bit 6 of the first mode byte set, also exercises the choice of receive interrupt source.

// File: rtl/uart_regcore_pkg.sv
package uart_regcore_pkg;

   // Register byte offsets; the bus decodes these exactly.
   localparam logic [7:0] OFS_MODE   = 8'h00;
   localparam logic [7:0] OFS_STAT   = 8'h04;
   localparam logic [7:0] OFS_CMD    = 8'h08;
   localparam logic [7:0] OFS_DATA   = 8'h0C;
   localparam logic [7:0] OFS_INT    = 8'h14;
   localparam logic [7:0] OFS_DIV_HI = 8'h18;
   localparam logic [7:0] OFS_DIV_LO = 8'h1C;

   // Bit of the first mode byte that selects queue-full as receive interrupt.
   localparam int unsigned MODE_RXSEL_BIT = 6;

   // Decoded actions of one command write.
   typedef struct packed {
      logic ptr_rst;
      logic rx_flush;
      logic tx_flush;
      logic brk_clr;
      logic tx_on;
      logic tx_off;
      logic rx_on;
      logic rx_off;
   } cmd_act_t;

endpackage

// File: rtl/uart_cmd_dec.sv
module uart_cmd_dec
   import uart_regcore_pkg::*;
(
   input  logic       we,
   input  logic [6:0] code,
   output cmd_act_t   act
);

   always_comb begin
      act          = '0;
      act.ptr_rst  = we && (code[5:4] == 2'd1);
      act.rx_flush = we && (code[5:4] == 2'd2);
      act.tx_flush = we && (code[5:4] == 2'd3);
      act.brk_clr  = we && (code[6:4] == 3'd5);
      act.tx_on    = we && (code[3:2] == 2'd1);
      act.tx_off   = we && (code[3:2] == 2'd2);
      act.rx_on    = we && (code[1:0] == 2'd1);
      act.rx_off   = we && (code[1:0] == 2'd2);
   end

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          pop,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   output logic [DW-1:0] head,
   output logic [CW-1:0] cnt,
   output logic          full,
   output logic          nonempty
);

   logic [DW-1:0] slot_q [DEPTH];
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_after_pop;
   logic [CW-1:0] wr_idx;
   logic          pop_eff;

   initial begin
      if (DEPTH < 2) $fatal(1, "uart_rxq: DEPTH must be at least 2");
   end

   assign pop_eff       = pop && (cnt_q != '0);
   assign cnt_after_pop = pop_eff ? cnt_q - CW'(1) : cnt_q;
   // A push into a full queue lands on the newest slot.
   assign wr_idx        = (cnt_after_pop == CW'(DEPTH)) ? CW'(DEPTH - 1) : cnt_after_pop;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DW-1:0] shifted;
      if (i < DEPTH - 1) begin : g_mid
         assign shifted = pop_eff ? slot_q[i+1] : slot_q[i];
      end else begin : g_last
         assign shifted = slot_q[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q[i] <= '0;
         else if (push && !flush && (wr_idx == CW'(i)))
            slot_q[i] <= push_data;
         else
            slot_q[i] <= shifted;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (flush)
         cnt_q <= '0;
      else if (push && (cnt_after_pop != CW'(DEPTH)))
         cnt_q <= cnt_after_pop + CW'(1);
      else
         cnt_q <= cnt_after_pop;
   end

   assign head     = (cnt_q != '0) ? slot_q[0] : '0;
   assign cnt      = cnt_q;
   assign full     = (cnt_q == CW'(DEPTH));
   assign nonempty = (cnt_q != '0);

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
   parameter int unsigned DW = 8
) (
   input  logic          tx_on,
   input  logic          sel_full,
   input  logic          q_nonempty,
   input  logic          q_full,
   input  logic          brk_flag,
   input  logic [DW-1:0] mask,
   output logic [DW-1:0] isr,
   output logic          irq
);

   logic rx_src;

   assign rx_src = sel_full ? q_full : q_nonempty;

   always_comb begin
      isr    = '0;
      isr[0] = tx_on;
      isr[1] = rx_src;
      isr[2] = brk_flag;
   end

   assign irq = |(isr & mask);

endmodule

// File: rtl/uart_regcore.sv
module uart_regcore
   import uart_regcore_pkg::*;
#(
   parameter int unsigned AW        = 6,
   parameter int unsigned DW        = 8,
   parameter int unsigned RXQ_DEPTH = 4,
   localparam int unsigned CW       = $clog2(RXQ_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          irq,
   output logic          tx_valid,
   input  logic          tx_ready,
   output logic [DW-1:0] tx_data,
   input  logic          rx_valid,
   output logic          rx_ready,
   input  logic [DW-1:0] rx_data,
   input  logic          brk_evt
);

   initial begin
      if (AW < 5) $fatal(1, "uart_regcore: AW must cover offset 0x1C");
      if (DW < 8) $fatal(1, "uart_regcore: DW must be at least 8");
   end

   // Address hits
   logic hit_mode, hit_stat, hit_cmd, hit_data, hit_int, hit_dhi, hit_dlo;
   assign hit_mode = (bus_addr == AW'(OFS_MODE));
   assign hit_stat = (bus_addr == AW'(OFS_STAT));
   assign hit_cmd  = (bus_addr == AW'(OFS_CMD));
   assign hit_data = (bus_addr == AW'(OFS_DATA));
   assign hit_int  = (bus_addr == AW'(OFS_INT));
   assign hit_dhi  = (bus_addr == AW'(OFS_DIV_HI));
   assign hit_dlo  = (bus_addr == AW'(OFS_DIV_LO));

   // Command decode
   cmd_act_t act;
   uart_cmd_dec u_dec (
      .we   (bus_wr && hit_cmd),
      .code (bus_wdata[6:0]),
      .act  (act)
   );

   // State
   logic [DW-1:0] mode_q [2];
   logic          ptr_q;
   logic          tx_en_q, rx_en_q;
   logic          tx_empty_q;
   logic [DW-1:0] tx_hold_q;
   logic          brk_q;
   logic [DW-1:0] mask_q;
   logic [DW-1:0] div_hi_q, div_lo_q;

   // Receive queue
   logic [DW-1:0] q_head;
   logic [CW-1:0] rxq_cnt;
   logic          q_full, q_nonempty;
   logic          q_push;
   logic [DW-1:0] q_push_data;

   assign rx_ready    = rx_en_q && !q_full && !brk_evt;
   assign q_push      = brk_evt || (rx_valid && rx_ready);
   assign q_push_data = brk_evt ? '0 : rx_data;

   uart_rxq #(.DW(DW), .DEPTH(RXQ_DEPTH)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (act.rx_flush),
      .pop       (bus_rd && hit_data),
      .push      (q_push),
      .push_data (q_push_data),
      .head      (q_head),
      .cnt       (rxq_cnt),
      .full      (q_full),
      .nonempty  (q_nonempty)
   );

   // Transmit side
   assign tx_valid = tx_en_q && !tx_empty_q;
   assign tx_data  = tx_hold_q;

   // Mode bytes and pointer
   for (genvar m = 0; m < 2; m++) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mode_q[m] <= '0;
         else if (bus_wr && hit_mode && (ptr_q == 1'(m)))
            mode_q[m] <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= 1'b0;
      else if (bus_wr && hit_mode)
         ptr_q <= 1'b1;
      else if (act.ptr_rst)
         ptr_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en_q    <= 1'b0;
         rx_en_q    <= 1'b0;
         tx_empty_q <= 1'b1;
         tx_hold_q  <= '0;
         brk_q      <= 1'b0;
         mask_q     <= '0;
         div_hi_q   <= '0;
         div_lo_q   <= '0;
      end else begin
         if (act.tx_on)
            tx_en_q <= 1'b1;
         else if (act.tx_off || act.tx_flush)
            tx_en_q <= 1'b0;

         if (act.rx_on)
            rx_en_q <= 1'b1;
         else if (act.rx_off || act.rx_flush)
            rx_en_q <= 1'b0;

         if (bus_wr && hit_data) begin
            tx_hold_q  <= bus_wdata;
            tx_empty_q <= 1'b0;
         end else if (act.tx_flush || (tx_valid && tx_ready)) begin
            tx_empty_q <= 1'b1;
         end

         if (brk_evt)
            brk_q <= 1'b1;
         else if (act.brk_clr)
            brk_q <= 1'b0;

         if (bus_wr && hit_int) mask_q   <= bus_wdata;
         if (bus_wr && hit_dhi) div_hi_q <= bus_wdata;
         if (bus_wr && hit_dlo) div_lo_q <= bus_wdata;
      end
   end

   // Interrupts
   logic [DW-1:0] isr;
   uart_irq_gen #(.DW(DW)) u_irq (
      .tx_on      (tx_en_q),
      .sel_full   (mode_q[0][MODE_RXSEL_BIT]),
      .q_nonempty (q_nonempty),
      .q_full     (q_full),
      .brk_flag   (brk_q),
      .mask       (mask_q),
      .isr        (isr),
      .irq        (irq)
   );

   // Read mux
   logic [DW-1:0] status;
   always_comb begin
      status    = '0;
      status[0] = q_nonempty;
      status[1] = q_full;
      status[2] = tx_en_q;
      status[3] = tx_empty_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_mode)      bus_rdata = mode_q[ptr_q];
      else if (hit_stat) bus_rdata = status;
      else if (hit_data) bus_rdata = q_head;
      else if (hit_int)  bus_rdata = isr;
      else if (hit_dhi)  bus_rdata = div_hi_q;
      else if (hit_dlo)  bus_rdata = div_lo_q;
   end

endmodule

// File: rtl/uart_regcore_chk.sv
module uart_regcore_chk #(
   parameter int unsigned AW    = 6,
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] bus_addr,
   input logic          bus_wr,
   input logic          bus_rd,
   input logic          tx_valid,
   input logic          tx_ready,
   input logic [DW-1:0] tx_data,
   input logic          rx_valid,
   input logic          rx_ready,
   input logic          brk_evt,
   input logic [CW-1:0] fifo_cnt,
   input logic          ptr,
   input logic          brk_flag
);

   // R6
   rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> (fifo_cnt < CW'(DEPTH)) && !brk_evt);

   // R6
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CW'(DEPTH));

   // R4
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !bus_wr) |=> (tx_valid && $stable(tx_data)));

   // R4
   tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && !bus_wr) |=> !tx_valid);

   // R8
   brk_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_evt |=> brk_flag);

   // R2
   ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(0)) |=> ptr);

   // R7
   pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == AW'(8'h0C) && fifo_cnt != '0 && !brk_evt
       && !(rx_valid && rx_ready) && !bus_wr)
      |=> (fifo_cnt == $past(fifo_cnt) - CW'(1)));

endmodule

bind uart_regcore uart_regcore_chk #(.AW(AW), .DW(DW), .DEPTH(RXQ_DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .tx_data  (tx_data),
   .rx_valid (rx_valid),
   .rx_ready (rx_ready),
   .brk_evt  (brk_evt),
   .fifo_cnt (rxq_cnt),
   .ptr      (ptr_q),
   .brk_flag (brk_q)
);

// File: tb/uart_regcore_tb_top.sv
module uart_regcore_tb_top;

   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq;
   logic       tx_valid;
   logic       tx_ready = 1'b0;
   logic [7:0] tx_data;
   logic       rx_valid = 1'b0;
   logic       rx_ready;
   logic [7:0] rx_data = '0;
   logic       brk_evt = 1'b0;

   always #5 clk = ~clk;

   uart_regcore dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .brk_evt(brk_evt)
   );

   // Reference model state
   logic [7:0] m_mr [2];
   logic       m_ptr, m_txen, m_rxen, m_txempty, m_brk;
   logic [7:0] m_txd, m_imr, m_dhi, m_dlo;
   logic [7:0] mq [$];

   int    n_cmp = 0;
   int    n_fail = 0;
   bit    done = 0;
   string cur_req = "R1";

   task automatic model_reset();
      m_mr[0] = 0; m_mr[1] = 0; m_ptr = 0; m_txen = 0; m_rxen = 0;
      m_txempty = 1; m_brk = 0; m_txd = 0; m_imr = 0; m_dhi = 0; m_dlo = 0;
      mq.delete();
   endtask

   function automatic logic [7:0] exp_isr();
      logic rxi;
      rxi = m_mr[0][6] ? (mq.size() == DEPTH) : (mq.size() != 0);
      return {5'b0, m_brk, rxi, m_txen};
   endfunction

   function automatic logic [7:0] exp_rdata();
      case (bus_addr)
         6'h00: return m_mr[m_ptr];
         6'h04: return {4'b0, m_txempty, m_txen, mq.size() == DEPTH, mq.size() != 0};
         6'h0C: return (mq.size() != 0) ? mq[0] : 8'h00;
         6'h14: return exp_isr();
         6'h18: return m_dhi;
         6'h1C: return m_dlo;
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      logic etv;
      etv = m_txen && !m_txempty;
      chk("rdata", bus_rdata, exp_rdata());
      chk("irq", {7'b0, irq}, {7'b0, |(exp_isr() & m_imr)});
      chk("tx_valid", {7'b0, tx_valid}, {7'b0, etv});
      if (etv) chk("tx_data", tx_data, m_txd);
      chk("rx_ready", {7'b0, rx_ready},
          {7'b0, m_rxen && (mq.size() < DEPTH) && !brk_evt});
   endtask

   task automatic model_step();
      logic txv, rxr, hs, pop, push, flush;
      logic [7:0] pd;
      txv   = m_txen && !m_txempty;
      rxr   = m_rxen && (mq.size() < DEPTH) && !brk_evt;
      hs    = txv && tx_ready;
      pop   = bus_rd && bus_addr == 6'h0C && mq.size() > 0;
      push  = brk_evt || (rx_valid && rxr);
      pd    = brk_evt ? 8'h00 : rx_data;
      flush = 0;
      if (hs) m_txempty = 1;
      if (bus_wr) begin
         case (bus_addr)
            6'h00: begin m_mr[m_ptr] = bus_wdata; m_ptr = 1; end
            6'h08: begin
               if (bus_wdata[5:4] == 1) m_ptr = 0;
               if (bus_wdata[5:4] == 2) begin m_rxen = 0; flush = 1; end
               if (bus_wdata[5:4] == 3) begin m_txen = 0; m_txempty = 1; end
               if (bus_wdata[6:4] == 5) m_brk = 0;
               if (bus_wdata[3:2] == 1) m_txen = 1;
               else if (bus_wdata[3:2] == 2) m_txen = 0;
               if (bus_wdata[1:0] == 1) m_rxen = 1;
               else if (bus_wdata[1:0] == 2) m_rxen = 0;
            end
            6'h0C: begin m_txd = bus_wdata; m_txempty = 0; end
            6'h14: m_imr = bus_wdata;
            6'h18: m_dhi = bus_wdata;
            6'h1C: m_dlo = bus_wdata;
            default: ;
         endcase
      end
      if (pop) void'(mq.pop_front());
      if (push) begin
         if (mq.size() == DEPTH) mq[DEPTH-1] = pd;
         else mq.push_back(pd);
      end
      if (flush) mq.delete();
      if (brk_evt) m_brk = 1;
   endtask

   task automatic tick();
      #1;
      compare_all();
      @(posedge clk);
      model_step();
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; brk_evt = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wr(logic [5:0] a, logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1; tick();
   endtask

   task automatic look(logic [5:0] a);
      bus_addr = a; tick();
   endtask

   task automatic rd(logic [5:0] a);
      bus_addr = a; bus_rd = 1; tick();
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;

      cur_req = "R1";   // reset values
      look(6'h04); look(6'h00); look(6'h14); look(6'h0C);

      cur_req = "R2";   // mode pointer
      wr(6'h00, 8'h11); look(6'h00);
      wr(6'h00, 8'h22); wr(6'h00, 8'h33); look(6'h00);
      wr(6'h08, 8'h10); look(6'h00);

      cur_req = "R3";   // enable fields, reserved code
      wr(6'h08, 8'h04); look(6'h04);
      wr(6'h08, 8'h0F); look(6'h04);
      wr(6'h08, 8'h08); look(6'h04);
      wr(6'h08, 8'h01); wr(6'h08, 8'h02); look(6'h04);

      cur_req = "R4";   // transmit handshake
      wr(6'h08, 8'h04);
      wr(6'h0C, 8'hA5); look(6'h04); idle(3);
      tx_ready = 1; tick(); tx_ready = 0; look(6'h04);
      wr(6'h0C, 8'h5A); tx_ready = 1; look(6'h04); tx_ready = 0;

      cur_req = "R5";   // pending byte while off, then reset
      wr(6'h08, 8'h08); wr(6'h0C, 8'h3C); idle(2); look(6'h04);
      wr(6'h08, 8'h30); look(6'h04);
      wr(6'h08, 8'h04); idle(2);

      cur_req = "R11";  // mask
      wr(6'h14, 8'h01); look(6'h14);
      wr(6'h14, 8'h02); look(6'h14);

      cur_req = "R6";   // fill the queue past its depth
      wr(6'h08, 8'h01);
      rx_valid = 1;
      for (int i = 0; i < 6; i++) begin
         rx_data = 8'h40 + 8'(i); bus_addr = 6'h04; tick();
      end
      rx_valid = 0;

      cur_req = "R10";  // receive interrupt follows full
      wr(6'h08, 8'h10); wr(6'h00, 8'h40); look(6'h14);

      cur_req = "R8";   // break when full overwrites newest
      brk_evt = 1; bus_addr = 6'h14; tick(); look(6'h14);

      cur_req = "R7";   // drain and read empty
      for (int i = 0; i < 5; i++) rd(6'h0C);
      look(6'h14);

      cur_req = "R12";  // clear break flag, pointer reset too
      wr(6'h14, 8'h04); look(6'h14);
      wr(6'h08, 8'h50); look(6'h14); look(6'h00);

      cur_req = "R8";   // break with receiver off
      wr(6'h08, 8'h02); brk_evt = 1; bus_addr = 6'h0C; tick(); rd(6'h0C);

      cur_req = "R9";   // receiver reset, then reset plus enable
      wr(6'h08, 8'h01); rx_valid = 1; rx_data = 8'h77; idle(2); rx_valid = 0;
      wr(6'h08, 8'h20); look(6'h04);
      wr(6'h08, 8'h01); rx_valid = 1; rx_data = 8'h88; tick(); rx_valid = 0;
      wr(6'h08, 8'h21); look(6'h04); rx_valid = 1; rx_data = 8'h99; tick();
      rx_valid = 0; look(6'h0C);

      cur_req = "R13";  // divider bytes, ignored writes, unused reads
      wr(6'h18, 8'h12); wr(6'h1C, 8'h34); look(6'h18); look(6'h1C);
      wr(6'h04, 8'hFF); wr(6'h10, 8'hFF); look(6'h04);
      look(6'h08); look(6'h10); look(6'h24);

      done = 1;
      summary();
      $finish;
   end

endmodule